// File: doc/BRIEF.md
# Multichannel Ping-Pong Sample Release Buffer

This block collects output samples for up to four channels and holds them until an external release strobe arrives. It keeps two banks of per-channel storage. One bank fills from the sample stream. The other bank holds the frame that is currently presented to the serial output stage. The strobe swaps the two roles in a single cycle. The frame that was just completed then appears on a wide parallel bus together with a one-cycle valid pulse, and filling continues at once in the other bank.

The number of active channels is one, two or four, selected by a mode input. An active channel that received no sample since the previous release repeats its last presented value, and this raises a sticky underrun flag. A second sample for the same channel inside one filling period replaces the first one, and this raises a sticky overrun flag.

Top module: `sample_release_buffer`

## Requirements
- R1: After reset, frame_valid is low, frame_data is all zero, and both flags are low. No frame is presented until the first release strobe.
- R2: A write to an active channel is stored in the filling bank. It does not change frame_data before the next release strobe.
- R3: When rel_strobe is sampled high, frame_valid is high for exactly the following cycle. From that cycle on, frame_data shows the completed bank and holds it unchanged until the next release.
- R4: ch_mode encoding: 0 selects one active channel (channel 0), 1 selects two (channels 0 and 1), and 2 or 3 selects four. Channel i occupies frame_data bits [i*DW +: DW]. Lanes of inactive channels read zero.
- R5: A write whose wr_ch is not an active channel is ignored. It stores nothing and cannot raise the overrun flag.
- R6: An active channel with no write since the previous release repeats the value it showed in the previous frame. The underrun flag then rises in the cycle after the strobe and stays high until reset.
- R7: A second write to the same channel before the release overwrites the stored sample, so the last write wins. The overrun flag rises in the cycle after that write and stays high until reset.
- R8: A write in the same cycle as the release strobe belongs to the bank being closed. It appears in the frame released by that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Sample write strobe |
| wr_ch | input | 2 | Channel index of the sample |
| wr_data | input | 24 | Sample value |
| rel_strobe | input | 1 | Release strobe that swaps the banks |
| ch_mode | input | 2 | Active channel count selector |
| frame_valid | output | 1 | One-cycle pulse marking a new frame |
| frame_data | output | 96 | Per-channel frame, channel i at bits [i*24 +: 24] |
| underrun_flag | output | 1 | Sticky: a channel was repeated |
| overrun_flag | output | 1 | Sticky: a channel was written twice |

## Verification
The block has one register stage between each input edge and each of its results. The frame pulse and the new frame contents are due in the cycle after the edge that samples the strobe. The overrun flag is due in the cycle after the edge that takes the second write. The underrun flag is due in the cycle after the releasing edge. The bench drives stimulus on falling edges and samples outputs on the next falling edge, so every comparison lands exactly one register stage after its cause. A monitor pops the expected frame from a queue only when the pulse is seen, and it reports any pulse that arrives with no frame queued.

// File: rtl/srb_pkg.sv
package srb_pkg;

    typedef enum logic [1:0] {
        CH_ONE      = 2'd0,
        CH_TWO      = 2'd1,
        CH_FOUR     = 2'd2,
        CH_FOUR_ALT = 2'd3
    } ch_mode_e;

    // number of lanes the mode enables, before capping to the build width
    function automatic int unsigned mode_lanes(logic [1:0] m);
        case (ch_mode_e'(m))
            CH_ONE:  return 1;
            CH_TWO:  return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/srb_active_map.sv
module srb_active_map
    import srb_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic [1:0]        mode,
    output logic [NUM_CH-1:0] act
);

    int unsigned lanes;

    always_comb begin
        lanes = mode_lanes(mode);
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        assign act[g] = (lanes > unsigned'(g));
    end

endmodule

// File: rtl/srb_write_track.sv
module srb_write_track #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] wr_hit,
    input  logic              swap,
    output logic [NUM_CH-1:0] fresh,
    output logic              overrun
);

    typedef struct packed {
        logic [NUM_CH-1:0] written;
        logic              overrun;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (|(wr_hit & trk_q.written)) begin
            trk_d.overrun = 1'b1;
        end
        if (swap) begin
            trk_d.written = '0;
        end else begin
            trk_d.written = trk_q.written | wr_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    // channels fed in the bank being filled, including this cycle's write
    assign fresh   = trk_q.written | wr_hit;
    assign overrun = trk_q.overrun;

endmodule

// File: rtl/srb_bank_pair.sv
module srb_bank_pair #(
    parameter int NUM_CH = 4,
    parameter int DW     = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CH-1:0]    wr_hit,
    input  logic [DW-1:0]        wr_data,
    input  logic                 swap,
    input  logic [NUM_CH-1:0]    fresh,
    input  logic [NUM_CH-1:0]    act,
    output logic [NUM_CH*DW-1:0] rd_flat
);

    typedef logic [DW-1:0] word_t;

    typedef struct packed {
        logic                    wsel;   // bank being filled: 0 or 1
        word_t [NUM_CH-1:0]      bank0;
        word_t [NUM_CH-1:0]      bank1;
    } bp_t;

    bp_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (wr_hit[i]) begin
                if (s_q.wsel) s_d.bank1[i] = wr_data;
                else          s_d.bank0[i] = wr_data;
            end else if (swap && act[i] && !fresh[i]) begin
                // starved lane: carry the presented value into the closing bank
                if (s_q.wsel) s_d.bank1[i] = s_q.bank0[i];
                else          s_d.bank0[i] = s_q.bank1[i];
            end
        end
        if (swap) begin
            s_d.wsel = !s_q.wsel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_rd
        assign rd_flat[g*DW +: DW] = s_q.wsel ? s_q.bank0[g] : s_q.bank1[g];
    end

endmodule

// File: rtl/sample_release_buffer.sv
module sample_release_buffer #(
    parameter int NUM_CH = 4,
    parameter int DW     = 24,
    localparam int CW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CW-1:0]        wr_ch,
    input  logic [DW-1:0]        wr_data,
    input  logic                 rel_strobe,
    input  logic [1:0]           ch_mode,
    output logic                 frame_valid,
    output logic [NUM_CH*DW-1:0] frame_data,
    output logic                 underrun_flag,
    output logic                 overrun_flag
);

    typedef struct packed {
        logic              valid;
        logic [NUM_CH-1:0] lanes;
        logic              underrun;
    } top_t;

    top_t top_d, top_q;

    logic [NUM_CH-1:0]    act;
    logic [NUM_CH-1:0]    wr_hit;
    logic [NUM_CH-1:0]    fresh;
    logic [NUM_CH*DW-1:0] rd_flat;

    srb_active_map #(.NUM_CH(NUM_CH)) i_map (
        .mode (ch_mode),
        .act  (act)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
        assign wr_hit[g] = wr_en && (wr_ch == CW'(g)) && act[g];
    end

    srb_write_track #(.NUM_CH(NUM_CH)) i_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .swap    (rel_strobe),
        .fresh   (fresh),
        .overrun (overrun_flag)
    );

    srb_bank_pair #(.NUM_CH(NUM_CH), .DW(DW)) i_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wr_data (wr_data),
        .swap    (rel_strobe),
        .fresh   (fresh),
        .act     (act),
        .rd_flat (rd_flat)
    );

    always_comb begin
        top_d       = top_q;
        top_d.valid = rel_strobe;
        if (rel_strobe) begin
            top_d.lanes = act;
            if (|(act & ~fresh)) begin
                top_d.underrun = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_out
        assign frame_data[g*DW +: DW] = top_q.lanes[g] ? rd_flat[g*DW +: DW] : '0;
    end

    assign frame_valid   = top_q.valid;
    assign underrun_flag = top_q.underrun;

endmodule

// File: rtl/srb_checks.sv
module srb_checks #(
    parameter int NUM_CH = 4,
    parameter int DW     = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 rel_strobe,
    input logic [1:0]           ch_mode,
    input logic                 frame_valid,
    input logic [NUM_CH*DW-1:0] frame_data,
    input logic                 underrun_flag,
    input logic                 overrun_flag
);

    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else if (rel_strobe) seen_q <= 1'b1;
    end

    p_no_frame_before_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !frame_valid);

    p_frame_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_strobe |=> $stable(frame_data));

    p_release_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rel_strobe |=> frame_valid);

    p_pulse_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_strobe |=> !frame_valid);

    if (NUM_CH > 1) begin : g_single
        p_single_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (rel_strobe && ch_mode == 2'd0) |=> (frame_data[NUM_CH*DW-1:DW] == '0));
    end

    p_underrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_flag |=> underrun_flag);

    p_underrun_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun_flag) |-> $past(rel_strobe));

    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_flag |=> overrun_flag);

    p_overrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_flag) |-> $past(wr_en));

endmodule

bind sample_release_buffer srb_checks #(.NUM_CH(NUM_CH), .DW(DW)) i_srb_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .rel_strobe    (rel_strobe),
    .ch_mode       (ch_mode),
    .frame_valid   (frame_valid),
    .frame_data    (frame_data),
    .underrun_flag (underrun_flag),
    .overrun_flag  (overrun_flag)
);

// File: tb/test_sample_release_buffer.sv
`timescale 1ns/1ps
module test_sample_release_buffer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_ch = '0;
    logic [23:0] wr_data = '0;
    logic        rel_strobe = 1'b0;
    logic [1:0]  ch_mode = 2'd2;
    logic        frame_valid;
    logic [95:0] frame_data;
    logic        underrun_flag;
    logic        overrun_flag;

    always #10 clk = ~clk;   // 50 MHz

    sample_release_buffer i_sample_release_buffer (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_ch         (wr_ch),
        .wr_data       (wr_data),
        .rel_strobe    (rel_strobe),
        .ch_mode       (ch_mode),
        .frame_valid   (frame_valid),
        .frame_data    (frame_data),
        .underrun_flag (underrun_flag),
        .overrun_flag  (overrun_flag)
    );

    int compared = 0;
    int mismatched = 0;

    // reference model state
    logic [23:0] m_fill [4];
    logic [23:0] m_prev [4];
    bit          m_wr   [4];
    int          m_cnt = 4;
    bit          m_ovr = 0;
    bit          m_und = 0;
    logic [95:0] m_last = '0;
    logic [95:0] expq [$];

    task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_write(input int ch, input logic [23:0] v);
        if (ch < m_cnt) begin
            if (m_wr[ch]) m_ovr = 1;
            m_fill[ch] = v;
            m_wr[ch]   = 1;
        end
    endtask

    task automatic do_write(input int ch, input logic [23:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 2'(ch); wr_data = v;
        model_write(ch, v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        ch_mode = m;
        m_cnt = (m == 2'd0) ? 1 : (m == 2'd1) ? 2 : 4;
    endtask

    task automatic do_release(input bit with_wr, input int ch, input logic [23:0] v);
        logic [95:0] f;
        logic [23:0] x;
        @(negedge clk);
        rel_strobe = 1'b1;
        if (with_wr) begin
            wr_en = 1'b1; wr_ch = 2'(ch); wr_data = v;
            model_write(ch, v);
        end
        f = '0;
        for (int c = 0; c < 4; c++) begin
            if (c < m_cnt) begin
                x = m_wr[c] ? m_fill[c] : m_prev[c];
                if (!m_wr[c]) m_und = 1;
                m_prev[c] = x;
                f[c*24 +: 24] = x;
            end
            m_wr[c] = 0;
        end
        m_last = f;
        expq.push_back(f);
        @(negedge clk);
        rel_strobe = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic check_flags(input string tag);
        chk(underrun_flag == m_und, {tag, " R6 underrun flag"}, 96'(underrun_flag), 96'(m_und));
        chk(overrun_flag == m_ovr, {tag, " R7 overrun flag"}, 96'(overrun_flag), 96'(m_ovr));
    endtask

    // monitor: compares each released frame with the queued expectation
    initial begin
        logic [95:0] e;
        forever begin
            @(negedge clk);
            if (rst_n && frame_valid) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R3 frame pulse with none expected", frame_data, '0);
                end else begin
                    e = expq.pop_front();
                    chk(frame_data == e, "R3 R4 frame content", frame_data, e);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL R3 watchdog expired: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            m_fill[c] = '0; m_prev[c] = '0; m_wr[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(frame_valid == 1'b0, "R1 frame_valid after reset", 96'(frame_valid), '0);
        chk(frame_data == '0, "R1 frame_data after reset", frame_data, '0);
        check_flags("R1");

        // R2: four channels, stored but not visible before release
        set_mode(2'd2);
        do_write(0, 24'h111111);
        do_write(1, 24'h222222);
        do_write(2, 24'h333333);
        do_write(3, 24'h444444);
        chk(frame_data == '0, "R2 no change before release", frame_data, '0);
        do_release(0, 0, '0);
        @(negedge clk);
        chk(frame_valid == 1'b0, "R3 pulse lasts one cycle", 96'(frame_valid), '0);
        check_flags("R6 clean");

        // R3 hold while the other bank fills
        do_write(0, 24'hA00001);
        do_write(1, 24'hA00002);
        do_write(2, 24'hA00003);
        do_write(3, 24'hA00004);
        chk(frame_data == m_last, "R3 frame held during filling", frame_data, m_last);
        do_release(0, 0, '0);

        // R5 / R4: two channels, writes to channels 2 and 3 ignored
        set_mode(2'd1);
        do_write(0, 24'hB00010);
        do_write(1, 24'hB00011);
        do_write(3, 24'hB00013);
        do_write(3, 24'hB00023);
        do_write(2, 24'hB00012);
        check_flags("R5 ignored writes");
        do_release(0, 0, '0);
        @(negedge clk);
        chk(frame_data[95:48] == '0, "R4 inactive lanes zero in two-channel mode", 96'(frame_data[95:48]), '0);

        // R4: one channel
        set_mode(2'd0);
        do_write(0, 24'hC00020);
        do_write(1, 24'hC00021);
        do_release(0, 0, '0);
        check_flags("R4 single");

        // R7: double write, last wins
        set_mode(2'd3);
        do_write(0, 24'hD00030);
        do_write(1, 24'hD00031);
        do_write(2, 24'hD00032);
        do_write(3, 24'hD00033);
        chk(overrun_flag == 1'b0, "R7 no overrun yet", 96'(overrun_flag), '0);
        do_write(2, 24'hD000FF);
        check_flags("R7 second write");
        do_release(0, 0, '0);

        // R6: channel 2 starved, repeats previous value
        do_write(0, 24'hE00040);
        do_write(1, 24'hE00041);
        do_write(3, 24'hE00043);
        do_release(0, 0, '0);
        check_flags("R6 starved");

        // R8: write in the release cycle joins the closing frame
        do_write(0, 24'hF00050);
        do_write(1, 24'hF00051);
        do_write(2, 24'hF00052);
        do_release(1, 3, 24'hF00053);
        check_flags("R8 sticky");

        // back-to-back releases: second frame repeats everything
        do_release(0, 0, '0);
        do_release(0, 0, '0);

        repeat (4) @(negedge clk);
        chk(expq.size() == 0, "R3 every release produced a frame", 96'(expq.size()), '0);
        chk(frame_data == m_last, "R6 repeated frame held", frame_data, m_last);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule